// File: doc/BRIEF.md
# Dual-Mode Host Register Access Port

This block lets an external microcontroller read and write a file of 144 byte-wide registers (locations 00h to 8Fh) over a parallel 8-bit bus. Two independent static choices shape the access. The first is the bus style. In the separate-bus style the register address arrives on a dedicated 8-bit address input and data travels on the 8-bit data bus. In the shared-bus style the address and data take turns on the same 8-bit lines, and an address latch enable strobe captures the address. The second is the addressing style. Direct addressing uses the whole 8-bit address. Indirect addressing decodes only the address LSB, which picks either a pointer register or a data window that reaches the register named by the pointer.

All strobes are active low except the latch enable and are sampled on the system clock. A sequencer with three states tracks the bus cycle. ST_IDLE waits for an access. Transition T_START_WR goes to ST_WRITE when chip select and the write strobe are both low; this is checked before T_START_RD, which goes to ST_READ when chip select and the read strobe are both low. ST_READ returns through T_END_RD once either strobe rises. ST_WRITE keeps capturing address and data while the write strobe stays low. It then leaves through T_COMMIT when the write strobe rises with chip select still low, which performs the write, or through T_ABANDON when chip select rises first. Read data is returned combinationally while the read is active.

Top module: `hostbus_port`

## Requirements
- R1: With `ind_mode` = 0, the full 8-bit effective address selects the register that is read or written.
- R2: With `ind_mode` = 1, only bit 0 of the effective address is decoded: 0 selects the pointer register and 1 selects the data window. All other address bits have no effect.
- R3: A data window access reads or writes the register whose address is held in the pointer. Reading the pointer returns its value, and the pointer never changes on a window access.
- R4: With `bus_mux` = 0, the effective address is `addr_i` and data is carried on `ad_i`/`ad_o`.
- R5: With `bus_mux` = 1, the effective address is the value of `ad_i` captured at the first clock edge where `ale` is sampled low after being sampled high. It is held until the next such edge, and `addr_i` has no effect.
- R6: Reads from any location above 8Fh return 00h and writes to it change nothing, whether the location is reached directly or through the pointer.
- R7: `ad_oe` is 1 exactly while `cs_n` and `rd_n` are both 0, and then `ad_o` shows the addressed value in the same cycle. Otherwise `ad_o` is 00h.
- R8: A write takes effect at the first clock edge where `wr_n` is sampled 1 after being 0 while `cs_n` is still 0. It uses the address and data last sampled while `wr_n` was 0. If `cs_n` rises first, the write is dropped.
- R9: Reset (`rst_n` = 0) clears every register, the pointer and the address latch to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_mux | input | 1 | Static bus style: 0 separate address bus, 1 shared address/data bus |
| ind_mode | input | 1 | Static addressing style: 0 direct, 1 indirect |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ale | input | 1 | Address latch enable for the shared bus, active high |
| addr_i | input | 8 | Dedicated address bus |
| ad_i | input | 8 | Data bus input (address and data in shared style) |
| ad_o | output | 8 | Read data toward the bus |
| ad_oe | output | 1 | Output enable for `ad_o` (tri-state control) |

## Verification
On every cycle the assertions check four things: the output enable and its zeroed data while no read is active, that a write commit only follows a low write strobe under chip select, that the pointer only moves when a commit occurs, and that the address latch only changes after the latch enable is low. Out-of-range reads in direct mode are also checked per cycle. Only the bench scenarios can show that stored values reach the right location: window accesses land where the pointer says, the latch holds across several data phases, abandoned writes leave memory untouched, and addresses above 8Fh disturb no lower register.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

    localparam int HB_DW       = 8;
    localparam int HB_AW       = 8;
    localparam int HB_NUM_REGS = 144;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PTR  = 2'd1,
        TGT_REG  = 2'd2
    } tgt_kind_e;

    typedef struct packed {
        tgt_kind_e          kind;
        logic [HB_AW-1:0]   idx;
    } tgt_t;

    // Resolve an effective bus address into a target location.
    function automatic tgt_t resolve_target(
        input logic             indirect,
        input logic [HB_AW-1:0] bus_addr,
        input logic [HB_AW-1:0] pointer
    );
        tgt_t t;
        t.kind = TGT_NONE;
        t.idx  = '0;
        if (indirect) begin
            if (!bus_addr[0]) begin
                t.kind = TGT_PTR;
            end else if (int'(pointer) < HB_NUM_REGS) begin
                t.kind = TGT_REG;
                t.idx  = pointer;
            end
        end else if (int'(bus_addr) < HB_NUM_REGS) begin
            t.kind = TGT_REG;
            t.idx  = bus_addr;
        end
        return t;
    endfunction

endpackage

// File: rtl/hostbus_addr_latch.sv
module hostbus_addr_latch #(
    parameter int AW = hostbus_pkg::HB_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale,
    input  logic [AW-1:0] ad_i,
    output logic [AW-1:0] lat_q
);
    logic ale_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_q <= 1'b0;
            lat_q <= '0;
        end else begin
            ale_q <= ale;
            if (ale_q && !ale) begin
                lat_q <= ad_i;
            end
        end
    end
endmodule

// File: rtl/hostbus_ctrl.sv
module hostbus_ctrl
    import hostbus_pkg::*;
#(
    parameter int AW = HB_AW,
    parameter int DW = HB_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] eff_addr,
    input  logic [DW-1:0] wdata_in,
    output logic          wr_commit,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_data
);
    bus_state_e state_q, state_d;
    logic       capture;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        wr_commit = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n && !wr_n) begin          // T_START_WR
                    state_d = ST_WRITE;
                    capture = 1'b1;
                end else if (!cs_n && !rd_n) begin // T_START_RD
                    state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (cs_n || rd_n) begin            // T_END_RD
                    state_d = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (cs_n) begin                    // T_ABANDON
                    state_d = ST_IDLE;
                end else if (wr_n) begin           // T_COMMIT
                    state_d   = ST_IDLE;
                    wr_commit = 1'b1;
                end else begin
                    capture = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Address/data capture while the write strobe is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (capture) begin
            cap_addr <= eff_addr;
            cap_data <= wdata_in;
        end
    end
endmodule

// File: rtl/hostbus_regfile.sv
module hostbus_regfile
    import hostbus_pkg::*;
#(
    parameter int AW       = HB_AW,
    parameter int DW       = HB_DW,
    parameter int NUM_REGS = HB_NUM_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          indirect,
    input  logic          wr_commit,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] ptr_q
);
    logic [DW-1:0] mem [NUM_REGS];
    tgt_t          wr_tgt, rd_tgt;

    always_comb begin
        wr_tgt = resolve_target(indirect, wr_addr, ptr_q);
        rd_tgt = resolve_target(indirect, rd_addr, ptr_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            for (int i = 0; i < NUM_REGS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_commit) begin
            if (wr_tgt.kind == TGT_PTR) begin
                ptr_q <= wr_data[AW-1:0];
            end else if (wr_tgt.kind == TGT_REG) begin
                mem[wr_tgt.idx] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_tgt.kind)
            TGT_PTR:  rd_data = DW'(ptr_q);
            TGT_REG:  rd_data = mem[rd_tgt.idx];
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
    import hostbus_pkg::*;
#(
    parameter int AW       = HB_AW,
    parameter int DW       = HB_DW,
    parameter int NUM_REGS = HB_NUM_REGS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_mux,
    input  logic          ind_mode,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          ale,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe
);
    logic [AW-1:0] lat_q;
    logic [AW-1:0] eff_addr;
    logic          wr_commit;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] ptr_q;

    hostbus_addr_latch #(.AW(AW)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ale   (ale),
        .ad_i  (ad_i[AW-1:0]),
        .lat_q (lat_q)
    );

    assign eff_addr = bus_mux ? lat_q : addr_i;

    hostbus_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .eff_addr  (eff_addr),
        .wdata_in  (ad_i),
        .wr_commit (wr_commit),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data)
    );

    hostbus_regfile #(.AW(AW), .DW(DW), .NUM_REGS(NUM_REGS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .indirect  (ind_mode),
        .wr_commit (wr_commit),
        .wr_addr   (cap_addr),
        .wr_data   (cap_data),
        .rd_addr   (eff_addr),
        .rd_data   (rd_data),
        .ptr_q     (ptr_q)
    );

    always_comb begin
        ad_oe = !cs_n && !rd_n;
        ad_o  = ad_oe ? rd_data : '0;
    end
endmodule

// File: rtl/hostbus_port_chk.sv
module hostbus_port_chk #(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int NUM_REGS = 144
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_mux,
    input logic          ind_mode,
    input logic          cs_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          ale,
    input logic [AW-1:0] addr_i,
    input logic [DW-1:0] ad_o,
    input logic          ad_oe,
    input logic          wr_commit,
    input logic [AW-1:0] ptr_q,
    input logic [AW-1:0] lat_q
);
    // R7
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!ad_oe && ad_o == '0));

    // R8
    commit_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (!cs_n && wr_n && !$past(wr_n)));

    // R3
    ptr_moves_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ptr_q) |-> $past(wr_commit && ind_mode));

    // R5
    latch_on_ale_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_q) |-> !$past(ale));

    // R6
    out_of_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && !bus_mux && !ind_mode && int'(addr_i) >= NUM_REGS) |-> (ad_o == '0));
endmodule

bind hostbus_port hostbus_port_chk #(.AW(AW), .DW(DW), .NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_mux   (bus_mux),
    .ind_mode  (ind_mode),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ale       (ale),
    .addr_i    (addr_i),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .wr_commit (wr_commit),
    .ptr_q     (ptr_q),
    .lat_q     (lat_q)
);

// File: tb/hostbus_port_tb.sv
`timescale 1ns/1ps
module hostbus_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mux = 1'b0;
    logic       ind_mode = 1'b0;
    logic       cs_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic       ale = 1'b0;
    logic [7:0] addr_i = 8'hFF;
    logic [7:0] ad_i = 8'h00;
    logic [7:0] ad_o;
    logic       ad_oe;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    hostbus_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_mux(bus_mux), .ind_mode(ind_mode),
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .ale(ale),
        .addr_i(addr_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe)
    );

    // ---------------- behavioural reference model ----------------
    int m_mem [256];
    int m_ptr, m_lat, m_cap_a, m_cap_d;
    bit m_prev_ale, m_in_wr;

    function automatic int m_eff();
        return bus_mux ? m_lat : int'(addr_i);
    endfunction

    function automatic int m_read(input int a);
        if (ind_mode) begin
            if (a % 2 == 0) return m_ptr;
            return (m_ptr < 144) ? m_mem[m_ptr] : 0;
        end
        return (a < 144) ? m_mem[a] : 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_ptr = 0; m_lat = 0; m_cap_a = 0; m_cap_d = 0;
            m_prev_ale = 0; m_in_wr = 0;
        end else begin
            if (!m_in_wr) begin
                if (!cs_n && !wr_n) begin
                    m_in_wr = 1; m_cap_a = m_eff(); m_cap_d = int'(ad_i);
                end
            end else if (cs_n) begin
                m_in_wr = 0;
            end else if (!wr_n) begin
                m_cap_a = m_eff(); m_cap_d = int'(ad_i);
            end else begin
                m_in_wr = 0;
                if (ind_mode) begin
                    if (m_cap_a % 2 == 0) m_ptr = m_cap_d;
                    else if (m_ptr < 144) m_mem[m_ptr] = m_cap_d;
                end else if (m_cap_a < 144) begin
                    m_mem[m_cap_a] = m_cap_d;
                end
            end
            if (m_prev_ale && !ale) m_lat = int'(ad_i);
            m_prev_ale = ale;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R7: per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_oe, exp_d;
            exp_oe = (!cs_n && !rd_n) ? 1 : 0;
            exp_d  = exp_oe ? m_read(m_eff()) : 0;
            check("R7 per-cycle {oe,data}", {ad_oe, ad_o}, (exp_oe << 8) | exp_d);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic step(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic addr_phase(input logic [7:0] a);
        if (bus_mux) begin
            addr_i = 8'hFF; ad_i = a; ale = 1'b1; step();
            ale = 1'b0; step();
        end else begin
            addr_i = a;
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        addr_phase(a);
        ad_i = d; cs_n = 1'b0; wr_n = 1'b0; step(2);
        wr_n = 1'b1; step();
        cs_n = 1'b1; step();
    endtask

    task automatic data_read(input string tag, input logic [7:0] exp);
        cs_n = 1'b0; rd_n = 1'b0; ad_i = 8'h5A; step();
        check(tag, int'(ad_o), int'(exp));
        check({tag, " oe"}, int'(ad_oe), 1);
        rd_n = 1'b1; cs_n = 1'b1; step();
    endtask

    task automatic bus_read(input string tag, input logic [7:0] a, input logic [7:0] exp);
        addr_phase(a);
        data_read(tag, exp);
    endtask

    // ---------------- scenarios ----------------
    initial begin
        step(4);
        rst_n = 1'b1;
        step(2);

        // R9: reset state
        bus_read("R9 reset reg 00h", 8'h00, 8'h00);
        bus_read("R9 reset reg 8Fh", 8'h8F, 8'h00);
        ind_mode = 1'b1;
        bus_read("R9 reset pointer", 8'hFE, 8'h00);
        ind_mode = 1'b0;

        // R1/R4: direct, separate bus
        bus_write(8'h00, 8'h11);
        bus_write(8'h8F, 8'hF8);
        bus_write(8'h45, 8'hA5);
        bus_read("R1 direct 00h", 8'h00, 8'h11);
        bus_read("R1 direct 8Fh", 8'h8F, 8'hF8);
        bus_read("R4 direct 45h", 8'h45, 8'hA5);

        // R6: out of range
        bus_write(8'h90, 8'h77);
        bus_write(8'hFF, 8'h66);
        bus_read("R6 read 90h", 8'h90, 8'h00);
        bus_read("R6 read FFh", 8'hFF, 8'h00);
        bus_read("R6 10h untouched", 8'h10, 8'h00);
        bus_read("R6 00h untouched", 8'h00, 8'h11);

        // R7: strobe without chip select
        addr_i = 8'h45; rd_n = 1'b0; step();
        check("R7 oe without cs", int'(ad_oe), 0);
        check("R7 data without cs", int'(ad_o), 0);
        rd_n = 1'b1; step();

        // R8: write abandoned by chip select rising first
        addr_i = 8'h45; ad_i = 8'h3C; cs_n = 1'b0; wr_n = 1'b0; step(2);
        cs_n = 1'b1; step();
        wr_n = 1'b1; step();
        bus_read("R8 abandoned write", 8'h45, 8'hA5);
        // R8: last sampled data wins
        addr_i = 8'h20; ad_i = 8'h01; cs_n = 1'b0; wr_n = 1'b0; step();
        ad_i = 8'h02; step();
        check("R8 not yet committed", m_mem[32], 0);
        wr_n = 1'b1; ad_i = 8'hEE; step();
        cs_n = 1'b1; step();
        bus_read("R8 last data", 8'h20, 8'h02);

        // R2/R3: indirect, separate bus
        ind_mode = 1'b1;
        bus_write(8'hFE, 8'h45);
        bus_read("R3 window read", 8'hFF, 8'hA5);
        bus_write(8'hFF, 8'h5B);
        bus_read("R3 pointer no increment", 8'hFE, 8'h45);
        bus_read("R2 upper bits ignored (ptr)", 8'h02, 8'h45);
        bus_read("R2 upper bits ignored (win)", 8'h13, 8'h5B);
        bus_write(8'hFE, 8'h8F);
        bus_read("R3 window 8Fh", 8'hFF, 8'hF8);
        // R6 via pointer
        bus_write(8'hFE, 8'hA0);
        bus_write(8'hFF, 8'h99);
        bus_read("R6 window above 8Fh", 8'hFF, 8'h00);
        ind_mode = 1'b0;
        bus_read("R3 direct sees window write", 8'h45, 8'h5B);
        bus_read("R6 20h untouched", 8'h20, 8'h02);

        // R5: shared bus
        bus_mux = 1'b1;
        bus_write(8'h33, 8'hC3);
        bus_read("R5 mux direct 33h", 8'h33, 8'hC3);
        addr_i = 8'h45;
        data_read("R5 latch held, addr_i ignored", 8'hC3);
        data_read("R5 latch held again", 8'hC3);
        ind_mode = 1'b1;
        bus_write(8'hFE, 8'h33);
        bus_read("R5 mux indirect window", 8'hFF, 8'hC3);
        bus_write(8'hFF, 8'h7E);
        ind_mode = 1'b0;
        bus_read("R5 mux direct after window write", 8'h33, 8'h7E);
        bus_mux = 1'b0;
        bus_read("R4 separate bus 33h", 8'h33, 8'h7E);

        // R9: reset again clears everything
        rst_n = 1'b0; step(2); rst_n = 1'b1; step();
        bus_read("R9 cleared 33h", 8'h33, 8'h00);
        ind_mode = 1'b1;
        bus_read("R9 cleared pointer", 8'hFE, 8'h00);
        ind_mode = 1'b0;

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule